// File: doc/BRIEF.md
# Configurable NaN Propagation Unit

This block settles what a single-precision floating-point operation should return when NaN operands are involved. It takes three 32-bit operands and an operation-kind select. The select picks either a two-operand arithmetic operation, which uses A and B, or a fused multiply-add A*B+C. It reports whether a NaN result applies, gives that 32-bit NaN result, and raises an invalid-operation flag. An arithmetic datapath places it beside the main result path: when `nan_hit` is high, the datapath takes `nan_result` in place of its computed value and ORs `invalid_op` into its exception flags.

One encoding bit selects between two NaN conventions. In the legacy convention, a set fraction MSB marks a signalling NaN, and every NaN result collapses to a fixed default NaN. In the 2008 convention, a set fraction MSB marks a quiet NaN, and operand payloads propagate by a fixed priority after silencing. The two conventions also handle the infinity-times-zero-plus-NaN case of a fused multiply-add differently. The unit is purely combinational.

Top module: `nan_prop_unit`

## Requirements
- R1: An operand is a NaN when bits [30:23] are all ones and bits [22:0] are nonzero. `nan_hit` is high exactly when an active operand is a NaN. A and B are active for a two-operand operation (`is_fma`=0). A, B and C are active for a fused multiply-add (`is_fma`=1).
- R2: With `enc_2008`=0 (legacy), every result with `nan_hit` high is 0x7FBFFFFF, and operand payloads never appear.
- R3: With `enc_2008`=1 and a two-operand operation, the returned operand is chosen in this order: A if signalling, then B if signalling, then A if quiet, then B if quiet.
- R4: With `enc_2008`=1 and a fused multiply-add, signalling NaNs are searched in the order C, A, B, and quiet NaNs are then searched in the order C, A, B.
- R5: In 2008 mode, a chosen signalling operand is returned with bit 22 set. A chosen quiet operand is returned unchanged.
- R6: Bit 22 of a NaN means signalling in legacy mode and quiet in 2008 mode.
- R7: `invalid_op` is high whenever an active operand is a signalling NaN under the active encoding.
- R8: For a fused multiply-add where one of A and B is an infinity and the other is a zero (either sign), and C is a NaN, `invalid_op` and `nan_hit` are high. The result is 0x7FBFFFFF in legacy mode and C with bit 22 set in 2008 mode.
- R9: For a two-operand operation, C has no effect on any output.
- R10: When `nan_hit` is low, `nan_result` is 0 and `invalid_op` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_2008 | input | 1 | 1 selects the 2008 NaN convention, 0 the legacy one |
| is_fma | input | 1 | 1 selects a fused multiply-add A*B+C, 0 a two-operand operation |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| opnd_c | input | 32 | Operand C (addend, used only when `is_fma` is 1) |
| nan_hit | output | 1 | A NaN result applies |
| nan_result | output | 32 | The NaN to return, or 0 when `nan_hit` is low |
| invalid_op | output | 1 | Invalid-operation exception |

## Verification
The bound checker tests several properties on every input change. It checks that legacy results are always the default NaN. It checks that 2008 results are quiet NaNs whose payload comes from an active operand. It checks the idle outputs when no NaN applies and the invalid flag for the infinity-times-zero case. The exact priority choice among several NaN operands, and the per-mode meaning of bit 22, can only be shown by the bench's sweep. That sweep runs over special values, both modes and both operation kinds, and compares against an independent reference.

// File: rtl/nanprop_pkg.sv
`timescale 1ns/1ps
package nanprop_pkg;
    localparam int WORD_W = 32;
    localparam int FRAC_W = 23;
    localparam int EXP_W  = 8;
    localparam int QBIT   = FRAC_W - 1;
    localparam int NUM_OPS = 3;
    localparam int IDX_W  = $clog2(NUM_OPS);

    localparam logic [WORD_W-1:0] DNAN_LEGACY = 32'h7FBF_FFFF;

    typedef enum logic { ENC_LEGACY = 1'b0, ENC_2008 = 1'b1 } nan_enc_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
        logic is_inf;
        logic is_zero;
    } opnd_class_t;

    function automatic opnd_class_t classify(input logic [WORD_W-1:0] v, input nan_enc_e enc);
        opnd_class_t r;
        logic exp_ones, frac_nz, top_bit;
        exp_ones  = &v[WORD_W-2 -: EXP_W];
        frac_nz   = |v[FRAC_W-1:0];
        top_bit   = v[QBIT];
        r.is_nan  = exp_ones && frac_nz;
        r.is_inf  = exp_ones && !frac_nz;
        r.is_zero = (v[WORD_W-2:0] == '0);
        r.is_snan = r.is_nan && ((enc == ENC_LEGACY) ? top_bit : !top_bit);
        r.is_qnan = r.is_nan && !r.is_snan;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] quieten(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = v;
        r[QBIT] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/nan_classifier.sv
`timescale 1ns/1ps
module nan_classifier
    import nanprop_pkg::*;
#(
    parameter int N = NUM_OPS
) (
    input  logic [N-1:0][WORD_W-1:0] ops,
    input  nan_enc_e                 enc,
    output opnd_class_t [N-1:0]      cls
);
    for (genvar i = 0; i < N; i++) begin : g_cls
        assign cls[i] = classify(ops[i], enc);
    end
endmodule

// File: rtl/nan_selector.sv
`timescale 1ns/1ps
module nan_selector
    import nanprop_pkg::*;
#(
    parameter int N = NUM_OPS,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][WORD_W-1:0] ops,
    input  opnd_class_t [N-1:0]      cls,
    input  logic [N-1:0]             active,
    input  logic [N-1:0][IW-1:0]     order,
    output logic                     found,
    output logic [WORD_W-1:0]        picked
);
    // Pass 0 searches signalling NaNs, pass 1 quiet NaNs, each in 'order'.
    always_comb begin
        found  = 1'b0;
        picked = '0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < N; k++) begin
                if (!found && active[order[k]] &&
                    ((pass == 0) ? cls[order[k]].is_snan : cls[order[k]].is_qnan)) begin
                    found  = 1'b1;
                    picked = ops[order[k]];
                end
            end
        end
    end
endmodule

// File: rtl/nan_prop_unit.sv
`timescale 1ns/1ps
module nan_prop_unit
    import nanprop_pkg::*;
(
    input  logic        enc_2008,
    input  logic        is_fma,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] opnd_c,
    output logic        nan_hit,
    output logic [31:0] nan_result,
    output logic        invalid_op
);
    localparam int IA = 0, IB = 1, IC = 2;

    nan_enc_e                      enc;
    logic [NUM_OPS-1:0][WORD_W-1:0] ops;
    opnd_class_t [NUM_OPS-1:0]     cls;
    logic [NUM_OPS-1:0]            active;
    logic [NUM_OPS-1:0][IDX_W-1:0] order;
    logic [NUM_OPS-1:0]            nan_v, snan_v;
    logic                          sel_found;
    logic [WORD_W-1:0]             sel_val;
    logic                          inf_times_zero;

    assign enc     = enc_2008 ? ENC_2008 : ENC_LEGACY;
    assign ops[IA] = opnd_a;
    assign ops[IB] = opnd_b;
    assign ops[IC] = opnd_c;
    assign active  = is_fma ? 3'b111 : 3'b011;

    // 2008 fused multiply-add searches C first; other cases use A, B, C.
    always_comb begin
        if (is_fma && enc == ENC_2008) begin
            order[0] = IDX_W'(IC);
            order[1] = IDX_W'(IA);
            order[2] = IDX_W'(IB);
        end else begin
            order[0] = IDX_W'(IA);
            order[1] = IDX_W'(IB);
            order[2] = IDX_W'(IC);
        end
    end

    nan_classifier #(.N(NUM_OPS)) u_cls (
        .ops (ops),
        .enc (enc),
        .cls (cls)
    );

    nan_selector #(.N(NUM_OPS)) u_sel (
        .ops    (ops),
        .cls    (cls),
        .active (active),
        .order  (order),
        .found  (sel_found),
        .picked (sel_val)
    );

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_flags
        assign nan_v[i]  = cls[i].is_nan  && active[i];
        assign snan_v[i] = cls[i].is_snan && active[i];
    end

    assign inf_times_zero = is_fma && cls[IC].is_nan &&
                            ((cls[IA].is_inf && cls[IB].is_zero) ||
                             (cls[IA].is_zero && cls[IB].is_inf));

    always_comb begin
        nan_hit    = |nan_v;
        invalid_op = (|snan_v) || inf_times_zero;
        if (!nan_hit)
            nan_result = '0;
        else if (enc == ENC_LEGACY)
            nan_result = DNAN_LEGACY;
        else
            nan_result = sel_found ? quieten(sel_val) : DNAN_LEGACY;
    end
endmodule

// File: rtl/nan_prop_chk.sv
`timescale 1ns/1ps
module nan_prop_chk (
    input logic        enc_2008,
    input logic        is_fma,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] opnd_c,
    input logic        nan_hit,
    input logic [31:0] nan_result,
    input logic        invalid_op
);
    function automatic logic fnan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic logic finf(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] == 0);
    endfunction
    function automatic logic fzero(input logic [31:0] v);
        return v[30:0] == 0;
    endfunction

    always_comb begin
        a_r2_legacy_default: assert (!(!enc_2008 && nan_hit) || nan_result == 32'h7FBF_FFFF)
            else $error("legacy result not default NaN");
        a_r10_idle_outputs: assert (nan_hit || (nan_result == 32'h0 && !invalid_op))
            else $error("idle outputs not clear");
        a_r5_quiet_out: assert (!(enc_2008 && nan_hit) || (nan_result[30:22] == 9'h1FF))
            else $error("2008 result not a quiet NaN");
        a_r3_source_ab: assert (!(enc_2008 && nan_hit && !is_fma) ||
                                (nan_result == (opnd_a | 32'h0040_0000)) ||
                                (nan_result == (opnd_b | 32'h0040_0000)))
            else $error("two-operand result not from A or B");
        a_r4_source_abc: assert (!(enc_2008 && nan_hit && is_fma) ||
                                (nan_result == (opnd_a | 32'h0040_0000)) ||
                                (nan_result == (opnd_b | 32'h0040_0000)) ||
                                (nan_result == (opnd_c | 32'h0040_0000)))
            else $error("fma result not from an operand");
        a_r8_inf_zero: assert (!(is_fma && fnan(opnd_c) &&
                                 ((finf(opnd_a) && fzero(opnd_b)) || (fzero(opnd_a) && finf(opnd_b)))) ||
                                (invalid_op && nan_hit))
            else $error("inf*zero+NaN not flagged");
    end
endmodule

bind nan_prop_unit nan_prop_chk u_chk (
    .enc_2008   (enc_2008),
    .is_fma     (is_fma),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .opnd_c     (opnd_c),
    .nan_hit    (nan_hit),
    .nan_result (nan_result),
    .invalid_op (invalid_op)
);

// File: tb/nan_prop_unit_tb.sv
`timescale 1ns/1ps
module nan_prop_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_2008 = 1'b0;
    logic        is_fma = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        nan_hit, invalid_op;
    logic [31:0] nan_result;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    nan_prop_unit u_dut (
        .enc_2008 (enc_2008), .is_fma (is_fma),
        .opnd_a (opnd_a), .opnd_b (opnd_b), .opnd_c (opnd_c),
        .nan_hit (nan_hit), .nan_result (nan_result), .invalid_op (invalid_op)
    );

    function automatic logic [31:0] pat(input int i);
        case (i)
            0: return 32'h3F80_0000;  // 1.0
            1: return 32'h7F80_0000;  // +inf
            2: return 32'h0000_0000;  // +0
            3: return 32'h8000_0000;  // -0
            4: return 32'h7FC0_1234;  // NaN, bit22 set
            5: return 32'h7F80_0AB1;  // NaN, bit22 clear
            6: return 32'hFFC0_0055;  // negative NaN, bit22 set
            default: return 32'hFF80_0007; // negative NaN, bit22 clear
        endcase
    endfunction

    function automatic bit m_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic bit m_sig(input logic [31:0] v, input bit m2008);
        return m_nan(v) && (v[22] == !m2008);
    endfunction

    task automatic ref_model(input logic [31:0] a, b, c, input bit m, f,
                             output bit e_hit, output logic [31:0] e_res, output bit e_inv);
        logic [31:0] lst [3];
        int n;
        bit got;
        bit iz;
        if (f && m) begin lst[0] = c; lst[1] = a; lst[2] = b; n = 3; end
        else if (f)  begin lst[0] = a; lst[1] = b; lst[2] = c; n = 3; end
        else         begin lst[0] = a; lst[1] = b; lst[2] = 0; n = 2; end
        e_hit = 0; e_inv = 0; e_res = 0; got = 0;
        for (int k = 0; k < n; k++) begin
            if (m_nan(lst[k])) e_hit = 1;
            if (m_sig(lst[k], m)) e_inv = 1;
        end
        iz = f && m_nan(c) &&
             (((a[30:0] == 31'h7F80_0000) && (b[30:0] == 0)) ||
              ((a[30:0] == 0) && (b[30:0] == 31'h7F80_0000)));
        if (iz) e_inv = 1;
        if (e_hit) begin
            if (!m) e_res = 32'h7FBF_FFFF;
            else begin
                for (int k = 0; k < n; k++)
                    if (!got && m_sig(lst[k], m)) begin got = 1; e_res = lst[k] + (lst[k][22] ? 0 : 32'h0040_0000); end
                for (int k = 0; k < n; k++)
                    if (!got && m_nan(lst[k])) begin got = 1; e_res = lst[k]; end
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
        end
    endtask

    task automatic apply(input bit m, f, input logic [31:0] a, b, c);
        @(negedge clk);
        enc_2008 = m; is_fma = f; opnd_a = a; opnd_b = b; opnd_c = c;
        #1;
    endtask

    initial begin
        bit e_hit, e_inv;
        logic [31:0] e_res;
        string tag;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R10: quiescent inputs after reset give idle outputs
        apply(0, 0, 32'h0, 32'h0, 32'h0);
        chk("R10", "nan_hit", {31'b0, nan_hit}, 0);
        chk("R10", "result", nan_result, 0);
        chk("R10", "invalid", {31'b0, invalid_op}, 0);

        // Sweep: both modes, both kinds, all special-value triples
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 2; f++)
                for (int ia = 0; ia < 8; ia++)
                    for (int ib = 0; ib < 8; ib++)
                        for (int ic = 0; ic < 8; ic++) begin
                            apply(m[0], f[0], pat(ia), pat(ib), pat(ic));
                            ref_model(pat(ia), pat(ib), pat(ic), m[0], f[0], e_hit, e_res, e_inv);
                            if (!e_hit) tag = "R10";
                            else if (m == 0) tag = "R2";
                            else if (f == 1) tag = "R4";
                            else tag = "R3";
                            chk("R1", "nan_hit", {31'b0, nan_hit}, {31'b0, e_hit});
                            chk(tag, "result", nan_result, e_res);
                            chk("R7", "invalid", {31'b0, invalid_op}, {31'b0, e_inv});
                        end

        // R5: signalling NaN silenced; quiet returned as is
        apply(1, 0, 32'h7F80_0001, 32'h3F80_0000, 32'h0);
        chk("R5", "silenced", nan_result, 32'h7FC0_0001);
        apply(1, 0, 32'h3F80_0000, 32'hFFC0_0099, 32'h0);
        chk("R5", "quiet kept", nan_result, 32'hFFC0_0099);
        // R6: bit22 meaning per mode
        apply(0, 0, 32'h7FC0_0000, 32'h0, 32'h0);
        chk("R6", "legacy bit22 signals", {31'b0, invalid_op}, 1);
        apply(1, 0, 32'h7FC0_0000, 32'h0, 32'h0);
        chk("R6", "2008 bit22 quiet", {31'b0, invalid_op}, 0);
        // R8: inf*zero with quiet NaN addend
        apply(1, 1, 32'hFF80_0000, 32'h0, 32'h7FC0_0042);
        chk("R8", "2008 invalid", {31'b0, invalid_op}, 1);
        chk("R8", "2008 result", nan_result, 32'h7FC0_0042);
        apply(0, 1, 32'h8000_0000, 32'h7F80_0000, 32'h7F80_0042);
        chk("R8", "legacy invalid", {31'b0, invalid_op}, 1);
        chk("R8", "legacy result", nan_result, 32'h7FBF_FFFF);
        // R9: C ignored for two-operand operations
        apply(1, 0, 32'h7FC0_0011, 32'h3F80_0000, 32'h7F80_0001);
        chk("R9", "result", nan_result, 32'h7FC0_0011);
        chk("R9", "invalid", {31'b0, invalid_op}, 0);
        apply(1, 0, 32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0001);
        chk("R9", "nan_hit", {31'b0, nan_hit}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule